// File: doc/BRIEF.md
# AC-link Codec Register Access Controller

This block gives a host a small 32-bit register window through which it reads and writes the control registers of an audio codec on a serial AC-link. A write request puts the register index in the first command slot and the 16-bit value in the second. A read request puts only the index, with a read flag, in the first slot. The codec's reply arrives in the first two incoming slots, and the block captures it into readable fields. Sticky flags report each transfer. Software clears a flag by writing zero to its bit. The block also runs the cold-reset pulse on the codec reset line and the warm-reset pulse on SYNC. It tracks the codec-ready bit of the incoming tag.

`clk_i` is the bit clock. One link bit is driven and one is sampled per cycle. A frame is 256 cycles: a 16-bit tag, then two 20-bit slots sent MSB first, then zero fill. PCM slots are not driven.

Top module: `ac_link_ctrl`

## Requirements
- R1: The register map uses word offsets on `reg_addr_i`: 0 control, 1 command address, 2 command data, 3 transmit flags, 4 receive flags, and 5 to 7 read zero. While control bit 5 (start) is set and no reset is running, frames repeat every 256 cycles and SYNC is high for the first 16 cycles of each frame. With start clear, SYNC and `sdata_o` stay low.
- R2: Outgoing tag bit 15 (the first bit sent) is set when the frame carries a command. Bit 14 marks slot 1 valid and bit 13 marks slot 2 valid. A write sets both bits. A read sets only bit 14. All other bits are zero.
- R3: Slot 1 carries {read flag, 7-bit index, 12 zeros}. Slot 2 carries {16-bit value, 4 zeros} for a write and zeros for a read. Every slot is sent MSB first.
- R4: A write to the command address register (bit 19 read flag, bits 18:12 index) makes a command pending. The value is taken from bits 19:4 of the command data register. The pending command is loaded at the next frame start and sent in exactly one frame. A newer write before that load replaces it.
- R5: Transmit flag bit 31 is set when a command frame completes. Bit 30 is also set for a write, but not for a read.
- R6: When the incoming tag marks slot 1 valid, the index in bits 18:12 of that slot is captured. It reads back at bits 18:12 of offset 1, and receive flag bit 22 is set. When the tag marks slot 2 valid, bits 19:4 of that slot are captured. They read back at bits 19:4 of offset 2, and receive flag bit 21 is set.
- R7: Control bit 15 reads the codec-ready bit. It is updated from incoming tag bit 15 in every frame and cleared while a cold reset runs.
- R8: Writing control bit 11 drives `codec_rst_no` low for COLD_CYC cycles. During that time the link halts, any frame in progress is dropped, and bit 11 reads 1.
- R9: Writing control bit 10 holds SYNC high for WARM_CYC cycles with the link halted, and bit 10 reads 1. Afterwards the frame restarts at the tag.
- R10: Writing 0 to a flag bit clears it, and writing 1 leaves it. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| sync_o | output | 1 | Frame sync to codec |
| sdata_o | output | 1 | Serial data to codec |
| codec_rst_no | output | 1 | Codec reset, active low |
| sdata_i | input | 1 | Serial data from codec |

## Verification
The bench targets the following corner cases:
- A read request must leave the data-sent flag and slot 2 untouched. A design that waits on data would report a write.
- A second command written before the frame boundary must replace the first. A design that queues it would send an extra frame.
- Stopping the link or cold-resetting it mid-frame must drop the frame without raising a sent flag.
- A partial write to a flag register must clear only the bits written as zero.
- Codec-ready must fall when the codec stops reporting it. A latched flag would stay set.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;
  localparam int FRAME_LEN = 256;
  localparam int TAG_LEN   = 16;
  localparam int SLOT_W    = 20;
  localparam int HEAD_W    = TAG_LEN + 2 * SLOT_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int TAG_LAST  = TAG_LEN - 1;
  localparam int S1_LAST   = TAG_LEN + SLOT_W - 1;
  localparam int S2_FIRST  = TAG_LEN + SLOT_W;
  localparam int S2_LAST   = HEAD_W - 1;
  localparam int IDX_W     = 7;
  localparam int VAL_W     = 16;

  localparam int CTRL_READY = 15;
  localparam int CTRL_COLD  = 11;
  localparam int CTRL_WARM  = 10;
  localparam int CTRL_START = 5;
  localparam int ADDR_RD    = 19;
  localparam int ADDR_LSB   = 12;
  localparam int DATA_LSB   = 4;
  localparam int TX_ADDR    = 31;
  localparam int TX_DATA    = 30;
  localparam int RX_ADDR    = 22;
  localparam int RX_DATA    = 21;

  typedef enum logic [2:0] {
    OFS_CTRL     = 3'd0,
    OFS_CMD_ADDR = 3'd1,
    OFS_CMD_DATA = 3'd2,
    OFS_TX_FLAGS = 3'd3,
    OFS_RX_FLAGS = 3'd4
  } reg_ofs_e;

  typedef struct packed {
    logic             valid;
    logic             rd;
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] val;
  } cmd_t;
endpackage

// File: rtl/ac_link_seq.sv
module ac_link_seq
  import ac_link_pkg::*;
#(
  parameter int COLD_CYC = 40,
  parameter int WARM_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cold_req_i,
  input  logic             warm_req_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cold_act_o,
  output logic             warm_act_o,
  output logic             sync_o,
  output logic             codec_rst_no
);
  localparam int COLD_W = $clog2(COLD_CYC + 1);
  localparam int WARM_W = $clog2(WARM_CYC + 1);

  logic [COLD_W-1:0] cold_q;
  logic [WARM_W-1:0] warm_q;
  logic [CNT_W-1:0]  cnt_q;

  assign cold_act_o   = cold_q != '0;
  assign warm_act_o   = warm_q != '0;
  assign run_o        = start_i && !cold_act_o && !warm_act_o;
  assign cnt_o        = cnt_q;
  assign codec_rst_no = !cold_act_o;
  assign sync_o       = warm_act_o || (run_o && cnt_q < CNT_W'(TAG_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cold_q <= '0;
    else if (cold_req_i)         cold_q <= COLD_W'(COLD_CYC);
    else if (cold_act_o)         cold_q <= cold_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 warm_q <= '0;
    else if (warm_req_i)         warm_q <= WARM_W'(WARM_CYC);
    else if (warm_act_o)         warm_q <= warm_q - 1'b1;
  end

  // idle parks at the last cycle so the first frame loads like any other
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= CNT_W'(FRAME_LEN - 1);
    else if (!run_o)                           cnt_q <= CNT_W'(FRAME_LEN - 1);
    else if (cnt_q == CNT_W'(FRAME_LEN - 1))   cnt_q <= '0;
    else                                       cnt_q <= cnt_q + 1'b1;
  end

  AST_SYNC_AT_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) && !warm_act_o |-> cnt_q == '0); // R1

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && $past(run_o) |->
      cnt_q == (($past(cnt_q) == CNT_W'(FRAME_LEN - 1)) ? '0 : $past(cnt_q) + 1'b1)); // R1
endmodule

// File: rtl/ac_link_ser.sv
module ac_link_ser
  import ac_link_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  cmd_t             pend_i,
  output logic             load_o,
  output logic             frame_done_o,
  output logic             done_rd_o,
  output logic             sdata_o
);
  cmd_t              cur_q;
  logic [TAG_LEN-1:0] tag;
  logic [SLOT_W-1:0]  w1, w2;
  logic [HEAD_W-1:0]  head, head_sh;

  assign load_o       = run_i && cnt_i == CNT_W'(FRAME_LEN - 1);
  assign frame_done_o = load_o && cur_q.valid;
  assign done_rd_o    = cur_q.rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q <= '0;
    else if (!run_i)  cur_q.valid <= 1'b0;
    else if (load_o)  cur_q <= pend_i;
  end

  always_comb begin
    tag = '0;
    tag[TAG_LEN-1] = cur_q.valid;
    tag[TAG_LEN-2] = cur_q.valid;
    tag[TAG_LEN-3] = cur_q.valid && !cur_q.rd;
    w1 = cur_q.valid ? {cur_q.rd, cur_q.idx, {(SLOT_W-IDX_W-1){1'b0}}} : '0;
    w2 = (cur_q.valid && !cur_q.rd) ? {cur_q.val, {(SLOT_W-VAL_W){1'b0}}} : '0;
  end

  assign head    = {tag, w1, w2};
  assign head_sh = head << cnt_i;
  assign sdata_o = run_i && cnt_i < CNT_W'(HEAD_W) && head_sh[HEAD_W-1];

  AST_FRAME_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !cur_q.valid || $past(pend_i.valid)); // R4

  AST_READ_SLOT2_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q.rd && cnt_i >= CNT_W'(S2_FIRST) && cnt_i <= CNT_W'(S2_LAST) |-> !sdata_o); // R3
endmodule

// File: rtl/ac_link_deser.sv
module ac_link_deser
  import ac_link_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cold_act_i,
  input  logic             sdata_i,
  output logic             ready_o,
  output logic [IDX_W-1:0] rx_idx_o,
  output logic [VAL_W-1:0] rx_val_o,
  output logic             idx_set_o,
  output logic             val_set_o
);
  logic [SLOT_W-2:0] sh_q;
  logic [SLOT_W-1:0] word;
  logic              v1_q, v2_q;
  logic              unused_word;

  assign word        = {sh_q, sdata_i};
  assign unused_word = ^word[DATA_LSB-1:0];
  assign idx_set_o   = run_i && cnt_i == CNT_W'(S1_LAST) && v1_q;
  assign val_set_o   = run_i && cnt_i == CNT_W'(S2_LAST) && v2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; v1_q <= 1'b0; v2_q <= 1'b0;
      rx_idx_o <= '0; rx_val_o <= '0;
    end else if (run_i) begin
      sh_q <= word[SLOT_W-2:0];
      if (cnt_i == CNT_W'(TAG_LAST)) {v1_q, v2_q} <= word[TAG_LEN-2 -: 2];
      if (idx_set_o) rx_idx_o <= word[ADDR_LSB +: IDX_W];
      if (val_set_o) rx_val_o <= word[DATA_LSB +: VAL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     ready_o <= 1'b0;
    else if (cold_act_i)                             ready_o <= 1'b0;
    else if (run_i && cnt_i == CNT_W'(TAG_LAST))     ready_o <= word[TAG_LEN-1];
  end

  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_act_i && !(run_i && cnt_i == CNT_W'(TAG_LAST)) |=> $stable(ready_o)); // R7

  AST_READY_COLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_act_i |=> !ready_o); // R7
endmodule

// File: rtl/ac_link_ctrl.sv
module ac_link_ctrl
  import ac_link_pkg::*;
#(
  parameter int COLD_CYC = 40,
  parameter int WARM_CYC = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sync_o,
  output logic        sdata_o,
  output logic        codec_rst_no,
  input  logic        sdata_i
);
  logic             start_q, pend_q, pend_rd_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [VAL_W-1:0] data_q;
  logic             tx_a_q, tx_d_q, rx_a_q, rx_d_q;
  logic             run, cold_act, warm_act, load, frame_done, done_rd;
  logic             ready, idx_set, val_set;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] rx_idx;
  logic [VAL_W-1:0] rx_val;
  logic             wr_ctrl, wr_addr, wr_data, wr_tx, wr_rx;
  logic             unused_wdata;
  cmd_t             pend;

  assign wr_ctrl      = reg_we_i && reg_addr_i == OFS_CTRL;
  assign wr_addr      = reg_we_i && reg_addr_i == OFS_CMD_ADDR;
  assign wr_data      = reg_we_i && reg_addr_i == OFS_CMD_DATA;
  assign wr_tx        = reg_we_i && reg_addr_i == OFS_TX_FLAGS;
  assign wr_rx        = reg_we_i && reg_addr_i == OFS_RX_FLAGS;
  assign unused_wdata = ^reg_wdata_i;
  assign pend         = '{valid: pend_q, rd: pend_rd_q, idx: pend_idx_q, val: data_q};

  ac_link_seq #(.COLD_CYC(COLD_CYC), .WARM_CYC(WARM_CYC)) u_seq (
    .clk_i, .rst_ni, .start_i(start_q),
    .cold_req_i(wr_ctrl && reg_wdata_i[CTRL_COLD]),
    .warm_req_i(wr_ctrl && reg_wdata_i[CTRL_WARM]),
    .run_o(run), .cnt_o(cnt), .cold_act_o(cold_act), .warm_act_o(warm_act),
    .sync_o, .codec_rst_no
  );

  ac_link_ser u_ser (
    .clk_i, .rst_ni, .run_i(run), .cnt_i(cnt), .pend_i(pend),
    .load_o(load), .frame_done_o(frame_done), .done_rd_o(done_rd), .sdata_o
  );

  ac_link_deser u_deser (
    .clk_i, .rst_ni, .run_i(run), .cnt_i(cnt), .cold_act_i(cold_act), .sdata_i,
    .ready_o(ready), .rx_idx_o(rx_idx), .rx_val_o(rx_val),
    .idx_set_o(idx_set), .val_set_o(val_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0; pend_q <= 1'b0; pend_rd_q <= 1'b0;
      pend_idx_q <= '0; data_q <= '0;
    end else begin
      if (wr_ctrl) start_q <= reg_wdata_i[CTRL_START];
      if (wr_data) data_q  <= reg_wdata_i[DATA_LSB +: VAL_W];
      if (wr_addr) begin
        pend_q     <= 1'b1;
        pend_rd_q  <= reg_wdata_i[ADDR_RD];
        pend_idx_q <= reg_wdata_i[ADDR_LSB +: IDX_W];
      end else if (load) begin
        pend_q <= 1'b0;
      end
    end
  end

  // sticky flags: set wins over a write-zero clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_a_q <= 1'b0; tx_d_q <= 1'b0; rx_a_q <= 1'b0; rx_d_q <= 1'b0;
    end else begin
      if (frame_done)                            tx_a_q <= 1'b1;
      else if (wr_tx && !reg_wdata_i[TX_ADDR])   tx_a_q <= 1'b0;
      if (frame_done && !done_rd)                tx_d_q <= 1'b1;
      else if (wr_tx && !reg_wdata_i[TX_DATA])   tx_d_q <= 1'b0;
      if (idx_set)                               rx_a_q <= 1'b1;
      else if (wr_rx && !reg_wdata_i[RX_ADDR])   rx_a_q <= 1'b0;
      if (val_set)                               rx_d_q <= 1'b1;
      else if (wr_rx && !reg_wdata_i[RX_DATA])   rx_d_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_ofs_e'(reg_addr_i))
      OFS_CTRL: begin
        reg_rdata_o[CTRL_READY] = ready;
        reg_rdata_o[CTRL_COLD]  = cold_act;
        reg_rdata_o[CTRL_WARM]  = warm_act;
        reg_rdata_o[CTRL_START] = start_q;
      end
      OFS_CMD_ADDR: reg_rdata_o[ADDR_LSB +: IDX_W] = rx_idx;
      OFS_CMD_DATA: reg_rdata_o[DATA_LSB +: VAL_W] = rx_val;
      OFS_TX_FLAGS: begin
        reg_rdata_o[TX_ADDR] = tx_a_q;
        reg_rdata_o[TX_DATA] = tx_d_q;
      end
      OFS_RX_FLAGS: begin
        reg_rdata_o[RX_ADDR] = rx_a_q;
        reg_rdata_o[RX_DATA] = rx_d_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  AST_TX_ADDR_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |=> tx_a_q); // R5

  AST_READ_NO_DATA_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && done_rd && !tx_d_q |=> !tx_d_q); // R5

  AST_TX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx && !reg_wdata_i[TX_ADDR] && !frame_done |=> !tx_a_q); // R10

  AST_RX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rx && !reg_wdata_i[RX_DATA] && !val_set |=> !rx_d_q); // R10
endmodule

// File: tb/ac_link_ctrl_test.sv
module ac_link_ctrl_test;
  localparam int COLD = 40;
  localparam int WARM = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic        sdi = 1'b0;
  wire  [31:0] rdata;
  wire         sync, sdo, crst_n;

  always #5 clk = ~clk;

  ac_link_ctrl #(.COLD_CYC(COLD), .WARM_CYC(WARM)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sync_o(sync), .sdata_o(sdo),
    .codec_rst_no(crst_n), .sdata_i(sdi)
  );

  int checks = 0;
  int errors = 0;

  // codec behaviour
  bit        c_rdy, c_v1, c_v2;
  bit [6:0]  c_idx;
  bit [15:0] c_val;

  // reference model state
  bit        m_start, m_pend, m_prd, m_cv, m_crd;
  bit [6:0]  m_pidx, m_cidx, m_rxa;
  bit [15:0] m_data, m_cdata, m_rxd;
  bit        m_ta, m_td, m_fa, m_fd, m_rdy, m_t1, m_t2;
  int        m_cold, m_warm, m_cnt, m_sh;

  function automatic bit m_run();
    return m_start && m_cold == 0 && m_warm == 0;
  endfunction

  function automatic bit m_sdo();
    bit [55:0] h;
    if (!m_run() || m_cnt >= 56) return 1'b0;
    h = {m_cv, m_cv, m_cv && !m_crd, 13'd0,
         m_cv ? {m_crd, m_cidx, 12'd0} : 20'd0,
         (m_cv && !m_crd) ? {m_cdata, 4'd0} : 20'd0};
    return h[55 - m_cnt];
  endfunction

  function automatic bit codec_bit(int p);
    bit [55:0] h;
    h = {c_rdy, c_v1, c_v2, 13'd0, 1'b0, c_idx, 12'd0, c_val, 4'd0};
    return (p < 56) ? h[55 - p] : 1'b0;
  endfunction

  function automatic logic [31:0] m_rdata(int a);
    logic [31:0] r = '0;
    case (a)
      0: begin r[15] = m_rdy; r[11] = m_cold > 0; r[10] = m_warm > 0; r[5] = m_start; end
      1: r[18:12] = m_rxa;
      2: r[19:4]  = m_rxd;
      3: begin r[31] = m_ta; r[30] = m_td; end
      4: begin r[22] = m_fa; r[21] = m_fd; end
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_start = 0; m_pend = 0; m_prd = 0; m_cv = 0; m_crd = 0;
      m_pidx = 0; m_cidx = 0; m_rxa = 0; m_data = 0; m_cdata = 0; m_rxd = 0;
      m_ta = 0; m_td = 0; m_fa = 0; m_fd = 0; m_rdy = 0; m_t1 = 0; m_t2 = 0;
      m_cold = 0; m_warm = 0; m_cnt = 255; m_sh = 0;
    end else begin
      automatic bit run  = m_run();
      automatic bit load = run && m_cnt == 255;
      automatic bit done = load && m_cv;
      automatic int nsh  = ((m_sh << 1) | sdi) & 32'hFFFFF;
      automatic bit w0 = we && addr == 0, w1 = we && addr == 1, w2 = we && addr == 2;
      automatic bit w3 = we && addr == 3, w4 = we && addr == 4;
      if (done) m_ta = 1; else if (w3 && !wdata[31]) m_ta = 0;
      if (done && !m_crd) m_td = 1; else if (w3 && !wdata[30]) m_td = 0;
      if (m_cold > 0) m_rdy = 0;
      else if (run && m_cnt == 15) m_rdy = nsh[15];
      if (run && m_cnt == 35 && m_t1) begin m_fa = 1; m_rxa = nsh[18:12]; end
      else if (w4 && !wdata[22]) m_fa = 0;
      if (run && m_cnt == 55 && m_t2) begin m_fd = 1; m_rxd = nsh[19:4]; end
      else if (w4 && !wdata[21]) m_fd = 0;
      if (run && m_cnt == 15) begin m_t1 = nsh[14]; m_t2 = nsh[13]; end
      if (run) m_sh = nsh;
      if (!run) m_cv = 0;
      else if (load) begin m_cv = m_pend; m_crd = m_prd; m_cidx = m_pidx; m_cdata = m_data; end
      if (w1) begin m_pend = 1; m_prd = wdata[19]; m_pidx = wdata[18:12]; end
      else if (load) m_pend = 0;
      if (w2) m_data = wdata[19:4];
      if (w0) m_start = wdata[5];
      if (w0 && wdata[11]) m_cold = COLD; else if (m_cold > 0) m_cold--;
      if (w0 && wdata[10]) m_warm = WARM; else if (m_warm > 0) m_warm--;
      m_cnt = run ? (m_cnt + 1) % 256 : 255;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni) begin
      automatic string rq[8] = '{"R7", "R6", "R6", "R5", "R10", "R1", "R1", "R1"};
      chk(sync === (m_warm > 0 || (m_run() && m_cnt < 16)), (m_warm > 0) ? "R9" : "R1",
          32'(sync), 32'(m_warm > 0 || (m_run() && m_cnt < 16)));
      chk(sdo === m_sdo(), (m_cnt < 16) ? "R2" : "R3", 32'(sdo), 32'(m_sdo()));
      chk(crst_n === (m_cold == 0), "R8", 32'(crst_n), 32'(m_cold == 0));
      chk(rdata === m_rdata(addr), (we && addr == 1) ? "R4" : rq[addr], rdata, m_rdata(addr));
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #2 sdi = m_run() ? codec_bit(m_cnt) : 1'b0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1 we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0; wdata = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 addr = addr + 3'd1;
    end
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1 addr = a;
    @(negedge clk);
    chk(rdata === exp, req, rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(sync === 1'b0 && crst_n === 1'b1, "R1", {sync, crst_n}, 32'b01);
    rd_chk(3'd0, 32'h0, "R8");

    // cold reset then warm reset, codec reports ready
    c_rdy = 1;
    wr(3'd0, 32'h0);
    wr(3'd0, (32'd1 << 11) | (32'd1 << 5));
    rd_chk(3'd0, 32'h0000_0820, "R8");
    chk(crst_n === 1'b0, "R8", 32'(crst_n), 32'h0);
    idle(COLD + 4);
    chk(crst_n === 1'b1, "R8", 32'(crst_n), 32'h1);
    wr(3'd0, (32'd1 << 10) | (32'd1 << 5));
    @(negedge clk);
    chk(sync === 1'b1, "R9", 32'(sync), 32'h1);
    idle(WARM + 300);
    rd_chk(3'd0, 32'h0000_8020, "R7");

    // write command
    wr(3'd2, 32'hBEEF << 4);
    wr(3'd1, 32'h26 << 12);
    idle(600);
    rd_chk(3'd3, 32'hC000_0000, "R5");
    wr(3'd3, 32'h0);
    rd_chk(3'd3, 32'h0, "R10");

    // read command with codec reply
    c_v1 = 1; c_v2 = 1; c_idx = 7'h7C; c_val = 16'h1234;
    wr(3'd1, (32'd1 << 19) | (32'h7C << 12));
    idle(600);
    rd_chk(3'd3, 32'h8000_0000, "R5");
    rd_chk(3'd4, 32'h0060_0000, "R6");
    rd_chk(3'd1, 32'h7C << 12, "R6");
    rd_chk(3'd2, 32'h1234 << 4, "R6");

    // partial clear of receive flags
    c_v1 = 0; c_v2 = 0;
    idle(300);
    wr(3'd4, 32'd1 << 21);
    rd_chk(3'd4, 32'd1 << 21, "R10");

    // overwrite before frame boundary
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h11 << 12);
    wr(3'd1, (32'd1 << 19) | (32'h22 << 12));
    idle(600);
    rd_chk(3'd3, 32'h8000_0000, "R4");

    // stop mid-frame with a command in flight
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h33 << 12);
    idle(270);
    wr(3'd0, 32'h0);
    idle(40);
    rd_chk(3'd3, 32'h0, "R4");

    // codec drops ready
    c_rdy = 0;
    wr(3'd0, 32'd1 << 5);
    idle(600);
    rd_chk(3'd0, 32'h0000_0020, "R7");
    wr(3'd0, 32'h0);
    idle(300);
    rd_chk(3'd0, 32'h0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule